// File: doc/BRIEF.md
# Host Parallel Port with Status Polling

This block joins an external host to an internal processor bus through a byte-wide parallel port. It holds one inbound byte, which the host writes and the processor takes, and one outbound byte, which the processor writes and the host reads. Each holding register has an occupancy flag. The flags drive two pins, so the host can see whether the inbound register is occupied and whether the outbound register is vacant.

Each direction has its own mode input that selects active or passive handshaking. A flag pin works only while its own direction is passive and is forced low while that direction is active. The host can also read a status byte through the ordinary read cycle: it raises the status-select line while starting a read with the outbound direction passive. A status read is free of side effects. The processor cannot reach the status byte at all. While either direction is active, the channel-select pin turns into an output that carries the processor's outbound channel number.

The host strobes arrive with no timing relation to the block clock. They pass through a two-stage synchronizer, and the block acts on the detected edge: a write takes effect on the rising edge of the write strobe, and a read takes effect on the falling edge of the read strobe.

Top module: `hpio_port`

## Requirements
- R1: After reset both holding registers are vacant. With both modes passive, `in_full_pin` is 0, `out_empty_pin` is 1, `host_dout` is 0 and `sel0_oe` is 0.
- R2: A rising edge on `host_wr_n` stores `host_din` in the inbound register, shown on `cpu_in_data`, and marks the register occupied. A `cpu_in_rd` pulse marks it vacant.
- R3: A `cpu_out_wr` pulse stores `cpu_out_data` and marks the outbound register occupied. A falling edge on `host_rd_n` with `host_sel1` low puts that byte on `host_dout` and marks the register vacant.
- R4: A falling edge on `host_rd_n` while `host_sel1` is high and `out_mode_active` is 0 puts a status byte on `host_dout`. Bits 7..3 are 0, bit 2 is `in_mode_active`, bit 1 is the inbound-occupied pin value and bit 0 is the outbound-vacant pin value.
- R5: A status read leaves both holding registers and both flags unchanged.
- R6: `in_full_pin` is 0 whenever `in_mode_active` is 1, whatever the outbound mode. The underlying occupancy is kept, and it shows again on the pin when the inbound direction returns to passive.
- R7: `out_empty_pin` is 0 whenever `out_mode_active` is 1, whatever the inbound mode.
- R8: Status bits 1 and 0 always equal the values that `in_full_pin` and `out_empty_pin` carry when the read starts.
- R9: While `out_mode_active` is 1, `host_sel1` has no effect: a read returns the outbound byte and marks the outbound register vacant.
- R10: While either mode is active, `sel0_oe` is 1 and `sel0_out` equals `cpu_chan`. While both modes are passive, `sel0_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_din | input | 8 | Data from the host, sampled on a write |
| host_wr_n | input | 1 | Host write strobe, asynchronous, active low |
| host_rd_n | input | 1 | Host read strobe, asynchronous, active low |
| host_sel1 | input | 1 | Status-select line for host reads |
| host_dout | output | 8 | Byte returned by the latest host read |
| in_full_pin | output | 1 | Inbound-occupied flag pin, mode-gated |
| out_empty_pin | output | 1 | Outbound-vacant flag pin, mode-gated |
| sel0_out | output | 1 | Channel-select value driven while a direction is active |
| sel0_oe | output | 1 | Output enable for the channel-select pin |
| in_mode_active | input | 1 | Inbound direction mode, 1 = active |
| out_mode_active | input | 1 | Outbound direction mode, 1 = active |
| cpu_chan | input | 1 | Outbound channel number chosen by the processor |
| cpu_in_data | output | 8 | Inbound register contents |
| cpu_in_rd | input | 1 | Processor take of the inbound byte, one-cycle pulse |
| cpu_out_data | input | 8 | Byte the processor writes outbound |
| cpu_out_wr | input | 1 | Processor write to the outbound register, one-cycle pulse |

## Verification
The bench polls status while the inbound register is occupied and the outbound register is loaded, then reads the outbound byte. A design in which the poll drains the outbound register would return a vacant flag, or stale data, on that read. With the inbound direction active, the bench checks that the flag pin drops low, that the occupancy returns once the mode goes passive again, and that status bit 1 follows the gated pin and not the hidden state. It also raises the status-select line while the outbound direction is active. A design that still honoured the line there would return status instead of data and would leave the outbound register occupied.

// File: rtl/hpio_pkg.sv
// Package: shared constants for the host parallel port.
// Assumes the data path is at least three bits wide, so the status byte fits.
package hpio_pkg;
    localparam int STAT_OUT_EMPTY = 0;
    localparam int STAT_IN_FULL   = 1;
    localparam int STAT_IN_ACTIVE = 2;
    localparam int STAT_USED      = 3;

    typedef enum logic {
        MODE_PASSIVE = 1'b0,
        MODE_ACTIVE  = 1'b1
    } hpio_mode_e;
endpackage

// File: rtl/hpio_sync.sv
// Module: hpio_sync
// Two-stage synchronizer for a vector of asynchronous host lines.
// Assumes each line stays stable for at least two clocks around every change.
module hpio_sync #(
    parameter int          WIDTH     = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Two-flop resynchronization of each line.
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1[gi] <= RST_VAL[gi];
                    stage2[gi] <= RST_VAL[gi];
                end else begin
                    stage1[gi] <= async_i[gi];
                    stage2[gi] <= stage1[gi];
                end
            end
        end
    endgenerate

    assign sync_o = stage2;
endmodule

// File: rtl/hpio_buffers.sv
// Module: hpio_buffers
// Holds the inbound and outbound bytes and their raw occupancy flags.
// Assumes event inputs are single-cycle pulses in the clock domain. When a set
// and a clear of the same flag coincide, the new data and the set win.
module hpio_buffers #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_evt,
    input  logic [DATA_W-1:0] host_din,
    input  logic              host_drain_evt,
    input  logic              cpu_in_rd,
    input  logic              cpu_out_wr,
    input  logic [DATA_W-1:0] cpu_out_data,
    output logic [DATA_W-1:0] in_buf,
    output logic              in_full,
    output logic [DATA_W-1:0] out_buf,
    output logic              out_empty
);
    // Inbound register: host fills, processor drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_buf  <= '0;
            in_full <= 1'b0;
        end else if (host_wr_evt) begin
            in_buf  <= host_din;
            in_full <= 1'b1;
        end else if (cpu_in_rd) begin
            in_full <= 1'b0;
        end
    end

    // Outbound register: processor fills, host drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_buf   <= '0;
            out_empty <= 1'b1;
        end else if (cpu_out_wr) begin
            out_buf   <= cpu_out_data;
            out_empty <= 1'b0;
        end else if (host_drain_evt) begin
            out_empty <= 1'b1;
        end
    end
endmodule

// File: rtl/hpio_hostside.sv
// Module: hpio_hostside
// Gates the flags by mode, builds the status byte, steers host reads and
// drives the channel-select pin. Assumes rd_start is a single-cycle pulse.
module hpio_hostside
    import hpio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              sel1_sync,
    input  logic              in_mode_active,
    input  logic              out_mode_active,
    input  logic              in_full,
    input  logic              out_empty,
    input  logic [DATA_W-1:0] out_buf,
    input  logic              cpu_chan,
    output logic              in_full_pin,
    output logic              out_empty_pin,
    output logic [DATA_W-1:0] host_dout,
    output logic              drain_evt,
    output logic              poll_evt,
    output logic              sel0_out,
    output logic              sel0_oe
);
    localparam int RSV_W = DATA_W - STAT_USED;

    hpio_mode_e in_mode;
    hpio_mode_e out_mode;
    logic [DATA_W-1:0] status_byte;

    // Decode the per-direction mode inputs.
    always_comb begin
        in_mode  = hpio_mode_e'(in_mode_active);
        out_mode = hpio_mode_e'(out_mode_active);
    end

    // Flag pins work only while their own direction is passive.
    always_comb begin
        in_full_pin   = (in_mode == MODE_PASSIVE) && in_full;
        out_empty_pin = (out_mode == MODE_PASSIVE) && out_empty;
    end

    // Status byte, built from the same gated values the pins carry.
    always_comb begin
        status_byte                 = {{RSV_W{1'b0}}, 3'b000};
        status_byte[STAT_IN_ACTIVE] = (in_mode == MODE_ACTIVE);
        status_byte[STAT_IN_FULL]   = in_full_pin;
        status_byte[STAT_OUT_EMPTY] = out_empty_pin;
    end

    // Classify a read start as a status poll or a data drain.
    always_comb begin
        poll_evt  = rd_start && sel1_sync && (out_mode == MODE_PASSIVE);
        drain_evt = rd_start && !poll_evt;
    end

    // Hold the byte returned by the latest host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_dout <= '0;
        end else if (poll_evt) begin
            host_dout <= status_byte;
        end else if (drain_evt) begin
            host_dout <= out_buf;
        end
    end

    // Channel-select pin turns into an output while either direction is active.
    always_comb begin
        sel0_oe  = (in_mode == MODE_ACTIVE) || (out_mode == MODE_ACTIVE);
        sel0_out = sel0_oe && cpu_chan;
    end
endmodule

// File: rtl/hpio_port.sv
// Module: hpio_port (top)
// Host parallel port: synchronizes the host strobes, detects their edges and
// ties the holding registers to the host-side logic. Assumes host_din and
// host_sel1 are steady while their strobe is low.
module hpio_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_din,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic              host_sel1,
    output logic [DATA_W-1:0] host_dout,
    output logic              in_full_pin,
    output logic              out_empty_pin,
    output logic              sel0_out,
    output logic              sel0_oe,
    input  logic              in_mode_active,
    input  logic              out_mode_active,
    input  logic              cpu_chan,
    output logic [DATA_W-1:0] cpu_in_data,
    input  logic              cpu_in_rd,
    input  logic [DATA_W-1:0] cpu_out_data,
    input  logic              cpu_out_wr
);
    localparam int NSYNC = 3;
    localparam int IX_WR = 0;
    localparam int IX_RD = 1;
    localparam int IX_S1 = 2;

    logic [NSYNC-1:0] raw_lines;
    logic [NSYNC-1:0] sync_lines;
    logic             wr_prev;
    logic             rd_prev;
    logic             wr_evt;
    logic             rd_start;
    logic             drain_evt;
    logic             poll_evt;
    logic             in_full;
    logic             out_empty;
    logic [DATA_W-1:0] in_buf;
    logic [DATA_W-1:0] out_buf;

    // Collect the asynchronous host lines.
    always_comb begin
        raw_lines        = '0;
        raw_lines[IX_WR] = host_wr_n;
        raw_lines[IX_RD] = host_rd_n;
        raw_lines[IX_S1] = host_sel1;
    end

    hpio_sync #(
        .WIDTH   (NSYNC),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    // Remember the previous synchronized strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b1;
            rd_prev <= 1'b1;
        end else begin
            wr_prev <= sync_lines[IX_WR];
            rd_prev <= sync_lines[IX_RD];
        end
    end

    // Write acts at the end of its strobe, read at the start of its strobe.
    always_comb begin
        wr_evt   = !wr_prev && sync_lines[IX_WR];
        rd_start = rd_prev && !sync_lines[IX_RD];
    end

    hpio_buffers #(
        .DATA_W (DATA_W)
    ) u_bufs (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_wr_evt    (wr_evt),
        .host_din       (host_din),
        .host_drain_evt (drain_evt),
        .cpu_in_rd      (cpu_in_rd),
        .cpu_out_wr     (cpu_out_wr),
        .cpu_out_data   (cpu_out_data),
        .in_buf         (in_buf),
        .in_full        (in_full),
        .out_buf        (out_buf),
        .out_empty      (out_empty)
    );

    hpio_hostside #(
        .DATA_W (DATA_W)
    ) u_host (
        .clk             (clk),
        .rst_n           (rst_n),
        .rd_start        (rd_start),
        .sel1_sync       (sync_lines[IX_S1]),
        .in_mode_active  (in_mode_active),
        .out_mode_active (out_mode_active),
        .in_full         (in_full),
        .out_empty       (out_empty),
        .out_buf         (out_buf),
        .cpu_chan        (cpu_chan),
        .in_full_pin     (in_full_pin),
        .out_empty_pin   (out_empty_pin),
        .host_dout       (host_dout),
        .drain_evt       (drain_evt),
        .poll_evt        (poll_evt),
        .sel0_out        (sel0_out),
        .sel0_oe         (sel0_oe)
    );

    assign cpu_in_data = in_buf;
endmodule

// File: rtl/hpio_port_chk.sv
// Module: hpio_port_chk
// Property checker bound to hpio_port. It watches the ports and the events
// that pass between the submodules.
module hpio_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_evt,
    input logic              poll_evt,
    input logic              drain_evt,
    input logic              cpu_in_rd,
    input logic              cpu_out_wr,
    input logic              in_full,
    input logic              out_empty,
    input logic [DATA_W-1:0] in_buf,
    input logic [DATA_W-1:0] out_buf,
    input logic              in_mode_active,
    input logic              out_mode_active,
    input logic              in_full_pin,
    input logic              out_empty_pin,
    input logic [DATA_W-1:0] host_dout,
    input logic              sel0_oe
);
    // R2: a host write leaves the inbound register occupied.
    assert_wr_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> in_full);

    // R3: a processor write leaves the outbound register occupied.
    assert_cpu_wr_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_out_wr |=> !out_empty);

    // R4, R8: a poll returns the mode bit and the pin values seen at its start.
    assert_status_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        poll_evt |=> (host_dout[2] == $past(in_mode_active))
                  && (host_dout[1] == $past(in_full_pin))
                  && (host_dout[0] == $past(out_empty_pin))
                  && (host_dout[DATA_W-1:3] == '0));

    // R5: a poll on its own changes no register and no flag.
    assert_poll_no_side_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_evt && !wr_evt && !cpu_in_rd && !cpu_out_wr) |=>
            $stable(in_full) && $stable(out_empty) && $stable(in_buf) && $stable(out_buf));

    // R6: the inbound flag pin is low while that direction is active.
    assert_in_pin_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_mode_active |-> !in_full_pin);

    // R7: the outbound flag pin is low while that direction is active.
    assert_out_pin_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode_active |-> !out_empty_pin);

    // R9: with the outbound direction active, every read drains.
    assert_active_read_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode_active |-> !poll_evt);

    // R10: an active direction enables the channel-select output.
    assert_sel0_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode_active || out_mode_active) |-> sel0_oe);

    // R3: a drain is never classed as a poll.
    assert_drain_not_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drain_evt |-> !poll_evt);
endmodule

bind hpio_port hpio_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_evt          (wr_evt),
    .poll_evt        (poll_evt),
    .drain_evt       (drain_evt),
    .cpu_in_rd       (cpu_in_rd),
    .cpu_out_wr      (cpu_out_wr),
    .in_full         (in_full),
    .out_empty       (out_empty),
    .in_buf          (in_buf),
    .out_buf         (out_buf),
    .in_mode_active  (in_mode_active),
    .out_mode_active (out_mode_active),
    .in_full_pin     (in_full_pin),
    .out_empty_pin   (out_empty_pin),
    .host_dout       (host_dout),
    .sel0_oe         (sel0_oe)
);

// File: tb/hpio_port_bench.sv
// Bench for hpio_port. A behavioural reference model updated by the stimulus
// tasks is compared with the outputs once every clock while no transfer is in
// flight. Directed checks are added at the points of interest.
module hpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_din = '0;
    logic       host_wr_n = 1'b1;
    logic       host_rd_n = 1'b1;
    logic       host_sel1 = 1'b0;
    logic [7:0] host_dout;
    logic       in_full_pin;
    logic       out_empty_pin;
    logic       sel0_out;
    logic       sel0_oe;
    logic       in_act = 1'b0;
    logic       out_act = 1'b0;
    logic       cpu_chan = 1'b0;
    logic [7:0] cpu_in_data;
    logic       cpu_in_rd = 1'b0;
    logic [7:0] cpu_out_data = '0;
    logic       cpu_out_wr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit busy = 1'b1;
    bit done = 1'b0;

    // Reference model state.
    logic [7:0] m_in_buf = '0;
    bit         m_in_full = 1'b0;
    logic [7:0] m_out_buf = '0;
    bit         m_out_empty = 1'b1;
    logic [7:0] m_dout = '0;

    always #2 clk = ~clk;

    hpio_port u_hpio_port (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_din        (host_din),
        .host_wr_n       (host_wr_n),
        .host_rd_n       (host_rd_n),
        .host_sel1       (host_sel1),
        .host_dout       (host_dout),
        .in_full_pin     (in_full_pin),
        .out_empty_pin   (out_empty_pin),
        .sel0_out        (sel0_out),
        .sel0_oe         (sel0_oe),
        .in_mode_active  (in_act),
        .out_mode_active (out_act),
        .cpu_chan        (cpu_chan),
        .cpu_in_data     (cpu_in_data),
        .cpu_in_rd       (cpu_in_rd),
        .cpu_out_data    (cpu_out_data),
        .cpu_out_wr      (cpu_out_wr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_in_pin();
        return m_in_full && !in_act;
    endfunction

    function automatic bit exp_out_pin();
        return m_out_empty && !out_act;
    endfunction

    // Per-clock comparison against the model when no transfer is in flight.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!busy && !done) begin
                check("R6 in_full_pin vs model", in_full_pin, exp_in_pin());
                check("R7 out_empty_pin vs model", out_empty_pin, exp_out_pin());
                check("R2 cpu_in_data vs model", cpu_in_data, m_in_buf);
                check("R3 host_dout vs model", host_dout, m_dout);
                check("R10 sel0_oe vs model", sel0_oe, in_act || out_act);
                if (in_act || out_act) check("R10 sel0_out vs model", sel0_out, cpu_chan);
            end
        end
    end

    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        busy = 1'b1;
        host_din = b;
        host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        m_in_buf = b;
        m_in_full = 1'b1;
        busy = 1'b0;
    endtask

    task automatic host_read(input logic s1);
        @(negedge clk);
        busy = 1'b1;
        if (s1 && !out_act) begin
            m_dout = {5'b0, in_act, exp_in_pin(), exp_out_pin()};
        end else begin
            m_dout = m_out_buf;
            m_out_empty = 1'b1;
        end
        host_sel1 = s1;
        host_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        host_sel1 = 1'b0;
        busy = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] b);
        @(negedge clk);
        busy = 1'b1;
        cpu_out_data = b;
        cpu_out_wr = 1'b1;
        @(negedge clk);
        cpu_out_wr = 1'b0;
        m_out_buf = b;
        m_out_empty = 1'b0;
        busy = 1'b0;
    endtask

    task automatic cpu_read();
        @(negedge clk);
        busy = 1'b1;
        cpu_in_rd = 1'b1;
        @(negedge clk);
        cpu_in_rd = 1'b0;
        m_in_full = 1'b0;
        busy = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 in_full_pin", in_full_pin, 1'b0);
        check("R1 out_empty_pin", out_empty_pin, 1'b1);
        check("R1 host_dout", host_dout, 8'h00);
        check("R1 sel0_oe", sel0_oe, 1'b0);
        busy = 1'b0;

        // R2: host write then processor take.
        host_write(8'hA5);
        check("R2 cpu_in_data", cpu_in_data, 8'hA5);
        check("R2 in_full_pin set", in_full_pin, 1'b1);
        cpu_read();
        @(negedge clk);
        check("R2 in_full_pin cleared", in_full_pin, 1'b0);

        // R3: processor write then host data read.
        cpu_write(8'h3C);
        @(negedge clk);
        check("R3 out_empty_pin cleared", out_empty_pin, 1'b0);
        host_read(1'b0);
        check("R3 host_dout data", host_dout, 8'h3C);
        check("R3 out_empty_pin set", out_empty_pin, 1'b1);

        // R4, R5, R8: poll with inbound occupied and outbound loaded.
        host_write(8'h5A);
        cpu_write(8'h77);
        host_read(1'b1);
        check("R4 status byte", host_dout, 8'h02);
        check("R5 in_full_pin after poll", in_full_pin, 1'b1);
        check("R5 out_empty_pin after poll", out_empty_pin, 1'b0);
        check("R5 cpu_in_data after poll", cpu_in_data, 8'h5A);
        host_read(1'b0);
        check("R5 outbound byte kept through poll", host_dout, 8'h77);

        // R6, R8: inbound active hides the occupied flag but keeps it.
        @(negedge clk);
        in_act = 1'b1;
        cpu_chan = 1'b1;
        @(negedge clk);
        check("R6 in_full_pin gated", in_full_pin, 1'b0);
        check("R10 sel0_oe with inbound active", sel0_oe, 1'b1);
        check("R10 sel0_out carries channel", sel0_out, 1'b1);
        host_read(1'b1);
        check("R8 status with inbound active", host_dout, 8'h05);
        @(negedge clk);
        in_act = 1'b0;
        @(negedge clk);
        check("R6 occupancy returns", in_full_pin, 1'b1);

        // R7, R9: outbound active gates the pin and ignores the status select.
        cpu_write(8'hC3);
        @(negedge clk);
        out_act = 1'b1;
        cpu_chan = 1'b0;
        @(negedge clk);
        check("R7 out_empty_pin low", out_empty_pin, 1'b0);
        check("R10 sel0_out follows channel", sel0_out, 1'b0);
        host_read(1'b1);
        check("R9 select ignored, data returned", host_dout, 8'hC3);
        check("R7 out_empty_pin still low when vacant", out_empty_pin, 1'b0);
        @(negedge clk);
        out_act = 1'b0;
        @(negedge clk);
        check("R9 read drained outbound", out_empty_pin, 1'b1);
        check("R10 sel0_oe back off", sel0_oe, 1'b0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule